// File: doc/BRIEF.md
# Column Hit Time-Stamp Capture

This block sits at the edge of one pixel column in a timing-layer sensor. While a bunch train is under way it counts bunch crossings, and each time the column raises its fast hit strobe it stores the crossing number current at that moment. The row number of the pixel that fired reaches the periphery later, over a slower separate path. When it arrives, the block pairs it with the oldest time stamp that still lacks a row and commits the pair to edge memory.

Between trains, a request port drains the committed (row, crossing) pairs in the order they were committed, then returns an end marker. A train-start pulse arms the logic before the first crossing. The same pulse zeroes the crossing counter, empties the memory and the pending queue, and clears the overflow flag. Row numbers that are still in flight when the train ends are paired after the end. Readout waits until none are pending.

Top module: `col_tstamp_capture`

## Requirements
- R1: After reset the block is idle: rd_vld_o, rd_end_o and ovf_o are 0, and a read request returns the end marker, since no entry is stored.
- R2: A train_start_i pulse arms capture and sets the crossing count to 0. It discards all stored and pending entries and clears ovf_o. A hit in the same cycle as train_start_i is not recorded.
- R3: While armed, the crossing count rises by one on each cycle with bx_en_i high and holds at 2^BX_W-1. A hit records the count held before that cycle's increment, which is the number of enabled crossings since train start.
- R4: A hit while armed queues its time stamp. Each row_vld_i cycle pairs row_i with the oldest queued time stamp, so entries are stored in hit order.
- R5: A row_vld_i cycle with no queued time stamp is ignored and stores nothing, even if a hit arrives in the same cycle.
- R6: Hits while not armed (after train_end_i, before the next train_start_i) are ignored.
- R7: After train_end_i, row numbers still pair with queued time stamps. Read requests are ignored while any time stamp is queued.
- R8: A hit is dropped and ovf_o set when the queue already holds PEND_DEPTH time stamps, or when stored plus queued entries equal MEM_DEPTH. ovf_o stays set until the next train_start_i.
- R9: When idle with nothing queued, a rd_req_i cycle gives the next stored entry one cycle later on rd_row_o/rd_bx_o, with rd_vld_o high for one cycle. Once every entry has been read, each further request gives rd_end_o high for one cycle. Requests while armed are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| train_start_i | input | 1 | Train-start pulse; arms and clears |
| train_end_i | input | 1 | Train-end pulse; disarms capture |
| bx_en_i | input | 1 | One cycle per bunch crossing |
| hit_i | input | 1 | Fast column hit strobe |
| row_vld_i | input | 1 | Row number valid on slow path |
| row_i | input | ROW_W | Row number of a fired pixel |
| rd_req_i | input | 1 | Read request between trains |
| rd_vld_o | output | 1 | Entry valid on read outputs |
| rd_end_o | output | 1 | All entries have been read |
| rd_row_o | output | ROW_W | Row of the entry read |
| rd_bx_o | output | BX_W | Crossing number of the entry read |
| ovf_o | output | 1 | Sticky hit-dropped flag for this train |

## Verification
Hits, row pairings, counter steps and control pulses take effect at the rising edge that samples them. An effect on ovf_o is visible right after that edge. A read request's entry or end marker appears on the outputs after the same edge and lasts one cycle. The bench therefore drives inputs on the falling edge and samples 1 ns after the following rising edge. Pairing and counting have no outputs of their own, so the bench checks them through the later readout: the crossing number and row returned for each entry, and the point at which the end marker appears.

// File: rtl/col_ts_pkg.sv
package col_ts_pkg;
  typedef enum logic {
    PH_IDLE  = 1'b0,
    PH_TRAIN = 1'b1
  } phase_e;
endpackage

// File: rtl/cts_bx_counter.sv
module cts_bx_counter #(
  parameter int unsigned BX_W = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            en_i,
  output logic [BX_W-1:0] cnt_o
);
  localparam logic [BX_W-1:0] BX_MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_o <= '0;
    else if (clr_i)                     cnt_o <= '0;
    else if (en_i && cnt_o != BX_MAX)   cnt_o <= cnt_o + 1'b1;
  end

  assert_cnt_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_o == '0);
  assert_cnt_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i && cnt_o != BX_MAX) |=> cnt_o == $past(cnt_o) + 1'b1);
  assert_cnt_hold_max_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && cnt_o == BX_MAX) |=> cnt_o == BX_MAX);
endmodule

// File: rtl/cts_fifo.sv
module cts_fifo #(
  parameter int unsigned W     = 12,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [W-1:0]  din_i,
  output logic [W-1:0]  dout_o,
  output logic [CW-1:0] cnt_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i && !clr_i) mem_q[wp_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_o <= '0;
    end else if (clr_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_o <= '0;
    end else begin
      if (push_i) wp_q <= ptr_next(wp_q);
      if (pop_i)  rp_q <= ptr_next(rp_q);
      case ({push_i, pop_i})
        2'b10:   cnt_o <= cnt_o + 1'b1;
        2'b01:   cnt_o <= cnt_o - 1'b1;
        default: cnt_o <= cnt_o;
      endcase
    end
  end

  assign dout_o = mem_q[rp_q];

  assert_fifo_no_push_full_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !clr_i) |-> cnt_o < CW'(DEPTH));
  assert_fifo_no_pop_empty_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !clr_i) |-> cnt_o != '0);
endmodule

// File: rtl/cts_store.sv
module cts_store #(
  parameter int unsigned ROW_W = 11,
  parameter int unsigned BX_W  = 12,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             wr_i,
  input  logic [ROW_W-1:0] wr_row_i,
  input  logic [BX_W-1:0]  wr_bx_i,
  input  logic             rd_i,
  output logic             rd_vld_o,
  output logic             rd_end_o,
  output logic [ROW_W-1:0] rd_row_o,
  output logic [BX_W-1:0]  rd_bx_o,
  output logic [CW-1:0]    cnt_o
);
  logic [ROW_W+BX_W-1:0] mem_q [DEPTH];
  logic [CW-1:0]         rd_ptr_q;

  always_ff @(posedge clk_i) begin
    if (wr_i && !clr_i) mem_q[cnt_o[AW-1:0]] <= {wr_row_i, wr_bx_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o    <= '0;
      rd_ptr_q <= '0;
      rd_vld_o <= 1'b0;
      rd_end_o <= 1'b0;
      rd_row_o <= '0;
      rd_bx_o  <= '0;
    end else begin
      rd_vld_o <= 1'b0;
      rd_end_o <= 1'b0;
      if (clr_i) begin
        cnt_o    <= '0;
        rd_ptr_q <= '0;
      end else begin
        if (wr_i) cnt_o <= cnt_o + 1'b1;
        if (rd_i) begin
          if (rd_ptr_q < cnt_o) begin
            rd_vld_o              <= 1'b1;
            {rd_row_o, rd_bx_o}   <= mem_q[rd_ptr_q[AW-1:0]];
            rd_ptr_q              <= rd_ptr_q + 1'b1;
          end else begin
            rd_end_o <= 1'b1;
          end
        end
      end
    end
  end

  assert_store_room_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !clr_i) |-> cnt_o < CW'(DEPTH));
  assert_one_marker_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rd_vld_o, rd_end_o}));
  assert_rd_within_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_vld_o |-> rd_ptr_q <= cnt_o);
endmodule

// File: rtl/col_tstamp_capture.sv
module col_tstamp_capture
  import col_ts_pkg::*;
#(
  parameter int unsigned ROW_W      = 11,
  parameter int unsigned BX_W       = 12,
  parameter int unsigned PEND_DEPTH = 4,
  parameter int unsigned MEM_DEPTH  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             train_start_i,
  input  logic             train_end_i,
  input  logic             bx_en_i,
  input  logic             hit_i,
  input  logic             row_vld_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic             rd_req_i,
  output logic             rd_vld_o,
  output logic             rd_end_o,
  output logic [ROW_W-1:0] rd_row_o,
  output logic [BX_W-1:0]  rd_bx_o,
  output logic             ovf_o
);
  localparam int unsigned PC_W = $clog2(PEND_DEPTH + 1);
  localparam int unsigned MC_W = $clog2(MEM_DEPTH + 1);
  localparam int unsigned RS_W = ((PC_W > MC_W) ? PC_W : MC_W) + 1;

  phase_e            phase_q;
  logic              ovf_q;
  logic              armed;
  logic [BX_W-1:0]   bx_cnt;
  logic [BX_W-1:0]   pend_bx;
  logic [PC_W-1:0]   pend_cnt;
  logic [MC_W-1:0]   store_cnt;
  logic [RS_W-1:0]   resv;
  logic              hit_seen, hit_ok, hit_drop, pair, rd_go;

  assign armed    = (phase_q == PH_TRAIN);
  // slots are reserved at hit time so every queued stamp is sure of a place
  assign resv     = RS_W'(pend_cnt) + RS_W'(store_cnt);
  assign hit_seen = armed && hit_i && !train_start_i;
  assign hit_ok   = hit_seen && (pend_cnt < PC_W'(PEND_DEPTH)) && (resv < RS_W'(MEM_DEPTH));
  assign hit_drop = hit_seen && !hit_ok;
  assign pair     = row_vld_i && (pend_cnt != '0) && !train_start_i;
  assign rd_go    = rd_req_i && !armed && (pend_cnt == '0) && !train_start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      ovf_q   <= 1'b0;
    end else begin
      if (train_start_i)    phase_q <= PH_TRAIN;
      else if (train_end_i) phase_q <= PH_IDLE;
      if (train_start_i)    ovf_q   <= 1'b0;
      else if (hit_drop)    ovf_q   <= 1'b1;
    end
  end

  assign ovf_o = ovf_q;

  cts_bx_counter #(.BX_W(BX_W)) u_bx_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (train_start_i),
    .en_i   (bx_en_i && armed),
    .cnt_o  (bx_cnt)
  );

  cts_fifo #(.W(BX_W), .DEPTH(PEND_DEPTH)) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (train_start_i),
    .push_i (hit_ok),
    .pop_i  (pair),
    .din_i  (bx_cnt),
    .dout_o (pend_bx),
    .cnt_o  (pend_cnt)
  );

  cts_store #(.ROW_W(ROW_W), .BX_W(BX_W), .DEPTH(MEM_DEPTH)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (train_start_i),
    .wr_i     (pair),
    .wr_row_i (row_i),
    .wr_bx_i  (pend_bx),
    .rd_i     (rd_go),
    .rd_vld_o (rd_vld_o),
    .rd_end_o (rd_end_o),
    .rd_row_o (rd_row_o),
    .rd_bx_o  (rd_bx_o),
    .cnt_o    (store_cnt)
  );

  assert_start_clears_ovf_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    train_start_i |=> !ovf_o);
  assert_ovf_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !train_start_i) |=> ovf_o);
  assert_full_sets_ovf_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && hit_i && !train_start_i && resv == RS_W'(MEM_DEPTH)) |=> ovf_o);
  assert_read_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_vld_o || rd_end_o) |-> !armed);
  assert_no_pair_overrun_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resv <= RS_W'(MEM_DEPTH));
endmodule

// File: tb/tb_col_tstamp_capture.sv
`timescale 1ns/1ps
module tb_col_tstamp_capture;
  localparam int unsigned ROW_W = 8;
  localparam int unsigned BX_W  = 4;
  localparam int unsigned PEND  = 4;
  localparam int unsigned MEM   = 8;

  typedef struct packed {
    logic       st, en, bx, hit, rv;
    logic [7:0] row;
    logic       rd;
    logic       e_vld, e_end, e_ovf;
    logic [7:0] e_row;
    logic [3:0] e_bx;
  } vec_t;

  // st en bx hit rv row rd | vld end ovf row bx
  localparam int unsigned NV = 18;
  localparam vec_t TBL [NV] = '{
    '{1'b1,1'b0,1'b0,1'b0,1'b0,8'h00,1'b0, 1'b0,1'b0,1'b0,8'h00,4'd0},
    '{1'b0,1'b0,1'b1,1'b0,1'b0,8'h00,1'b0, 1'b0,1'b0,1'b0,8'h00,4'd0},
    '{1'b0,1'b0,1'b1,1'b1,1'b0,8'h00,1'b0, 1'b0,1'b0,1'b0,8'h00,4'd0},
    '{1'b0,1'b0,1'b1,1'b0,1'b0,8'h00,1'b1, 1'b0,1'b0,1'b0,8'h00,4'd0},
    '{1'b0,1'b0,1'b0,1'b1,1'b0,8'h00,1'b0, 1'b0,1'b0,1'b0,8'h00,4'd0},
    '{1'b0,1'b0,1'b0,1'b0,1'b1,8'h21,1'b0, 1'b0,1'b0,1'b0,8'h00,4'd0},
    '{1'b0,1'b0,1'b1,1'b0,1'b1,8'h42,1'b0, 1'b0,1'b0,1'b0,8'h00,4'd0},
    '{1'b0,1'b0,1'b0,1'b0,1'b1,8'h55,1'b0, 1'b0,1'b0,1'b0,8'h00,4'd0},
    '{1'b0,1'b0,1'b1,1'b1,1'b0,8'h00,1'b0, 1'b0,1'b0,1'b0,8'h00,4'd0},
    '{1'b0,1'b1,1'b0,1'b0,1'b0,8'h00,1'b0, 1'b0,1'b0,1'b0,8'h00,4'd0},
    '{1'b0,1'b0,1'b0,1'b1,1'b0,8'h00,1'b0, 1'b0,1'b0,1'b0,8'h00,4'd0},
    '{1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,1'b1, 1'b0,1'b0,1'b0,8'h00,4'd0},
    '{1'b0,1'b0,1'b0,1'b0,1'b1,8'h63,1'b0, 1'b0,1'b0,1'b0,8'h00,4'd0},
    '{1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,1'b1, 1'b1,1'b0,1'b0,8'h21,4'd1},
    '{1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,1'b1, 1'b1,1'b0,1'b0,8'h42,4'd3},
    '{1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,1'b1, 1'b1,1'b0,1'b0,8'h63,4'd4},
    '{1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,1'b1, 1'b0,1'b1,1'b0,8'h00,4'd0},
    '{1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,1'b1, 1'b0,1'b1,1'b0,8'h00,4'd0}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             st = 1'b0, en = 1'b0, bx = 1'b0, hit = 1'b0, rv = 1'b0, rd = 1'b0;
  logic [ROW_W-1:0] row = '0;
  logic             rd_vld, rd_end, ovf;
  logic [ROW_W-1:0] rd_row;
  logic [BX_W-1:0]  rd_bx;
  int               n_tests = 0;
  int               n_fail  = 0;
  bit               done    = 1'b0;

  always #2.5 clk = ~clk;

  col_tstamp_capture #(
    .ROW_W(ROW_W), .BX_W(BX_W), .PEND_DEPTH(PEND), .MEM_DEPTH(MEM)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .train_start_i(st), .train_end_i(en),
    .bx_en_i(bx), .hit_i(hit), .row_vld_i(rv), .row_i(row), .rd_req_i(rd),
    .rd_vld_o(rd_vld), .rd_end_o(rd_end), .rd_row_o(rd_row), .rd_bx_o(rd_bx),
    .ovf_o(ovf)
  );

  task automatic step(input logic s, e, b, h, r, input logic [7:0] rw, input logic q);
    @(negedge clk);
    st = s; en = e; bx = b; hit = h; rv = r; row = rw; rd = q;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
  endtask

  task automatic expect_out(input string req, input logic ev, ee, eo,
                            input logic [7:0] er, input logic [3:0] eb);
    logic ok;
    n_tests++;
    ok = (rd_vld === ev) && (rd_end === ee) && (ovf === eo) &&
         (!ev || (rd_row === er && rd_bx === eb));
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got vld=%b end=%b ovf=%b row=%h bx=%0d, expected vld=%b end=%b ovf=%b row=%h bx=%0d",
               req, rd_vld, rd_end, ovf, rd_row, rd_bx, ev, ee, eo, er, eb);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (all requirements): got hung run, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    expect_out("R1 reset outputs", 1'b0, 1'b0, 1'b0, 8'h00, 4'd0);
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1);
    expect_out("R1 empty read gives end marker", 1'b0, 1'b1, 1'b0, 8'h00, 4'd0);
    idle();

    // vector table: covers R3 R4 R5 R6 R7 R9
    for (int i = 0; i < int'(NV); i++) begin
      step(TBL[i].st, TBL[i].en, TBL[i].bx, TBL[i].hit, TBL[i].rv, TBL[i].row, TBL[i].rd);
      expect_out($sformatf("R3 R4 R5 R6 R7 R9 table row %0d", i),
                 TBL[i].e_vld, TBL[i].e_end, TBL[i].e_ovf, TBL[i].e_row, TBL[i].e_bx);
    end
    idle();

    // R3 saturation of the crossing count
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
    for (int k = 0; k < 20; k++) step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0);
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h11, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1);
    expect_out("R3 count held at max", 1'b1, 1'b0, 1'b0, 8'h11, 4'd15);
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1);
    expect_out("R9 end after single entry", 1'b0, 1'b1, 1'b0, 8'h00, 4'd0);

    // R2 new train clears count and memory; hit on the start cycle is not recorded
    step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0);
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h12, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h13, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1);
    expect_out("R2 count restarts at zero, old entry gone", 1'b1, 1'b0, 1'b0, 8'h12, 4'd0);
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1);
    expect_out("R2 start-cycle hit not stored", 1'b0, 1'b1, 1'b0, 8'h00, 4'd0);

    // R8 pending queue full
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
    for (int k = 0; k < int'(PEND); k++) begin
      step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0);
      expect_out("R8 no overflow below queue depth", 1'b0, 1'b0, 1'b0, 8'h00, 4'd0);
    end
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0);
    expect_out("R8 queue full sets overflow", 1'b0, 1'b0, 1'b1, 8'h00, 4'd0);
    for (int k = 0; k < int'(PEND); k++) step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'(8'h30 + k), 1'b0);
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
    expect_out("R8 overflow sticky after end", 1'b0, 1'b0, 1'b1, 8'h00, 4'd0);
    for (int k = 0; k < int'(PEND); k++) begin
      step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1);
      expect_out("R8 kept entries read back", 1'b1, 1'b0, 1'b1, 8'(8'h30 + k), 4'd0);
    end
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1);
    expect_out("R8 dropped hit not stored", 1'b0, 1'b1, 1'b1, 8'h00, 4'd0);

    // R8 edge memory full
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
    expect_out("R2 start clears overflow", 1'b0, 1'b0, 1'b0, 8'h00, 4'd0);
    for (int k = 0; k < int'(MEM); k++) begin
      step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0);
      step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'(8'h80 + k), 1'b0);
    end
    expect_out("R8 no overflow at exactly full", 1'b0, 1'b0, 1'b0, 8'h00, 4'd0);
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0);
    expect_out("R8 memory full sets overflow", 1'b0, 1'b0, 1'b1, 8'h00, 4'd0);
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
    for (int k = 0; k < int'(MEM); k++) begin
      step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1);
      expect_out("R4 R9 full memory in hit order", 1'b1, 1'b0, 1'b1, 8'(8'h80 + k), 4'(k));
    end
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1);
    expect_out("R9 end after full memory", 1'b0, 1'b1, 1'b1, 8'h00, 4'd0);

    // R2 empty train leaves nothing to read
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1);
    expect_out("R2 memory cleared at train start", 1'b0, 1'b1, 1'b0, 8'h00, 4'd0);
    idle();

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule